// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Step Keyed Service

This block is a deadman timer that sits on a simple register bus. Software turns it on with one control bit. While it is on, it counts system clocks toward a programmable limit. To keep the system alive, software has to service the timer with two writes in order. The first write arms the timer with a fixed key. The second write carries a second fixed key and is accepted only while a service window is open near the end of the count. A correct service returns the count to zero and closes the window.

Every kind of misuse leaves a sticky status flag that stays set until reset. The misuses are a wrong first key, and a second write that comes unarmed, carries the wrong value or arrives outside the window. Running out the count also counts as a failure. Each failure also sets a common event flag, sets a sticky cause bit and raises a one-cycle reset request toward the system reset logic.

The bus port is a plain register port with no back-pressure. It accepts one write every cycle. Read data is combinational on the address. Each register has a normal write slot, a clear slot and a set slot, so a single write can change only the bits that are selected.

Top module: `keyed_deadman`

## Requirements
- R1: After reset, every readable register reads zero, except the limit (0x60) and window (0x70) registers, which read their reset parameters. `rst_req_o` is low.
- R2: Address bits 7:4 select the register. Bits 3:2 select the write form: 00 plain, 01 clear-selected-bits, 10 set-selected-bits, 11 no effect. Writes with bits 1:0 not zero have no effect. Control register 0x00 holds the enable in bit 15, and its other bits read 0.
- R3: While enabled, the count at 0x40 rises by one each clock. While disabled, it is held at zero.
- R4: Writes to the limit (0x60) and window (0x70) registers take effect only while the timer is disabled.
- R5: Status bit 0 (0x30) is 1 exactly while the timer is enabled and limit−window ≤ count < limit. The window start is 0 when window ≥ limit.
- R6: A plain write to 0x10 with bits 15:8 = 0x40 arms the timer. A following plain write to 0x20 with bits 7:0 = 0x08, made while the window is open, sets the count to 0 in that cycle and disarms.
- R7: A plain write to 0x10 while enabled whose bits 15:8 are not 0x40 sets status bit 7 and status bit 5. It also raises `rst_req_o` in the next cycle.
- R8: A plain write to 0x20 while enabled sets status bit 6 and status bit 5, raises `rst_req_o` and disarms the timer if any of these holds: the timer is unarmed, bits 7:0 are not 0x08, or the window is closed.
- R9: When the count reaches the limit without service, status bit 5 is set. `rst_req_o` is high for exactly one cycle, and the count then stays at the limit.
- R10: Status bits 5, 6 and 7 stay set until reset, and writes to 0x30 have no effect on them.
- R11: Register 0x80 bit 5 is set by every reset request. A clear-form write (0x84) with bit 5 set clears it.
- R12: In the cycle right after the enable bit is cleared, writes have no effect and reads return 0.
- R13: Key writes have no effect while the timer is disabled or when made through the set or clear forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 8 | Byte address: register, write form, alignment |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request on any failure |

## Verification
The assertions take for granted that at most one register write arrives per cycle and that the bus inputs are steady around each rising edge. They also assume the limit and window values fit the counter width, so the count bound and the service reset can be stated without overflow cases. The stimulus changes inputs only on the falling edge. It issues writes one at a time through a single task, and it picks limits of 3 to 7 and windows of 0 up to the limit. The sweep then places the second key at every count from 1 to the limit, so it reaches the last-window-cycle and just-expired corners.

// File: rtl/kd_pkg.sv
package kd_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  // register selector in address bits 7:4
  localparam logic [3:0] SEL_CTRL  = 4'h0;
  localparam logic [3:0] SEL_PRE   = 4'h1;
  localparam logic [3:0] SEL_CLR   = 4'h2;
  localparam logic [3:0] SEL_STAT  = 4'h3;
  localparam logic [3:0] SEL_CNT   = 4'h4;
  localparam logic [3:0] SEL_PER   = 4'h6;
  localparam logic [3:0] SEL_WIN   = 4'h7;
  localparam logic [3:0] SEL_CAUSE = 4'h8;

  localparam int unsigned EN_BIT    = 15;
  localparam int unsigned CAUSE_BIT = 5;
  localparam int unsigned ST_WIN    = 0;
  localparam int unsigned ST_EVT    = 5;
  localparam int unsigned ST_BAD2   = 6;
  localparam int unsigned ST_BAD1   = 7;

  localparam logic [7:0] KEY_ARM  = 8'h40;
  localparam logic [7:0] KEY_KICK = 8'h08;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'b00,
    WR_CLEAR = 2'b01,
    WR_SET   = 2'b10,
    WR_NONE  = 2'b11
  } wr_kind_e;

  typedef struct packed {
    logic ctrl;
    logic pre;
    logic clr;
    logic per;
    logic win;
    logic cause;
  } wr_strobe_t;

  function automatic logic [BUS_W-1:0] apply_word(input logic [BUS_W-1:0] cur,
                                                  input logic [BUS_W-1:0] din,
                                                  input wr_kind_e kind);
    case (kind)
      WR_PLAIN: apply_word = din;
      WR_CLEAR: apply_word = cur & ~din;
      WR_SET:   apply_word = cur | din;
      default:  apply_word = cur;
    endcase
  endfunction

  function automatic logic apply_bit(input logic cur, input logic din, input wr_kind_e kind);
    case (kind)
      WR_PLAIN: apply_bit = din;
      WR_CLEAR: apply_bit = cur & ~din;
      WR_SET:   apply_bit = cur | din;
      default:  apply_bit = cur;
    endcase
  endfunction

endpackage

// File: rtl/kd_bus_decode.sv
module kd_bus_decode
  import kd_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              blk_i,
  output wr_strobe_t        strb_o,
  output wr_kind_e          kind_o,
  output logic [3:0]        rsel_o
);

  logic aligned;
  logic plain;
  logic go;

  always_comb begin
    kind_o  = wr_kind_e'(addr_i[3:2]);
    rsel_o  = addr_i[7:4];
    aligned = (addr_i[1:0] == 2'b00);
    plain   = (kind_o == WR_PLAIN);
    go      = wr_en_i && !blk_i && aligned && (kind_o != WR_NONE);
    strb_o  = '0;
    if (go) begin
      case (rsel_o)
        SEL_CTRL:  strb_o.ctrl  = 1'b1;
        SEL_PRE:   strb_o.pre   = plain;   // keys accept plain form only
        SEL_CLR:   strb_o.clr   = plain;
        SEL_PER:   strb_o.per   = 1'b1;
        SEL_WIN:   strb_o.win   = 1'b1;
        SEL_CAUSE: strb_o.cause = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/kd_cfg_regs.sv
module kd_cfg_regs
  import kd_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PER_RST = 1000,
  parameter int unsigned WIN_RST = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_strobe_t       strb_i,
  input  wr_kind_e         kind_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             evt_i,
  output logic             en_o,
  output logic             blk_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] win_o,
  output logic             cause_o
);

  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);
  localparam logic [CNT_W-1:0] WIN_INIT = CNT_W'(WIN_RST);

  logic             en_q, en_d;
  logic             blk_q;
  logic             cause_q, cause_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] win_q, win_d;

  always_comb begin
    en_d    = en_q;
    per_d   = per_q;
    win_d   = win_q;
    cause_d = cause_q;
    if (strb_i.ctrl) en_d = apply_bit(en_q, wdata_i[EN_BIT], kind_i);
    if (strb_i.per && !en_q) per_d = CNT_W'(apply_word(BUS_W'(per_q), wdata_i, kind_i));
    if (strb_i.win && !en_q) win_d = CNT_W'(apply_word(BUS_W'(win_q), wdata_i, kind_i));
    if (strb_i.cause) cause_d = apply_bit(cause_q, wdata_i[CAUSE_BIT], kind_i);
    if (evt_i) cause_d = 1'b1;   // hardware set wins over software clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      blk_q   <= 1'b0;
      cause_q <= 1'b0;
      per_q   <= PER_INIT;
      win_q   <= WIN_INIT;
    end else begin
      en_q    <= en_d;
      blk_q   <= en_q & ~en_d;
      cause_q <= cause_d;
      per_q   <= per_d;
      win_q   <= win_d;
    end
  end

  assign en_o    = en_q;
  assign blk_o   = blk_q;
  assign per_o   = per_q;
  assign win_o   = win_q;
  assign cause_o = cause_q;

  AST_LIMITS_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> ($stable(per_q) && $stable(win_q))); // R4
  AST_BLACKOUT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q |=> ($stable(per_q) && $stable(win_q) && $stable(en_q))); // R12
  AST_CAUSE_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> cause_q); // R11

endmodule

// File: rtl/kd_count_window.sv
module kd_count_window #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             svc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             win_open_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             expired_q, expired_d;
  logic [CNT_W:0]   nxt;
  logic [CNT_W-1:0] start;

  always_comb begin
    nxt        = {1'b0, count_q} + 1'b1;
    start      = (win_i >= per_i) ? '0 : (per_i - win_i);
    win_open_o = en_i && (count_q >= start) && (count_q < per_i);
    expire_o   = en_i && !expired_q && !svc_i && (nxt >= {1'b0, per_i});

    count_d   = count_q;
    expired_d = expired_q;
    if (!en_i) begin
      count_d   = '0;
      expired_d = 1'b0;
    end else if (svc_i) begin
      count_d   = '0;
      expired_d = 1'b0;
    end else begin
      if (count_q < per_i) count_d = nxt[CNT_W-1:0];
      if (expire_o) expired_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else begin
      count_q   <= count_d;
      expired_q <= expired_d;
    end
  end

  assign count_o = count_q;

  AST_COUNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (count_q <= per_i)); // R9
  AST_SERVICE_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |=> (count_q == '0)); // R6
  AST_IDLE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_q == '0)); // R3

endmodule

// File: rtl/kd_key_guard.sv
module kd_key_guard
  import kd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        pre_wr_i,
  input  logic        clr_wr_i,
  input  logic [15:0] wdata_i,
  input  logic        win_open_i,
  input  logic        expire_i,
  output logic        svc_o,
  output logic        evt_o,
  output logic        bad1_o,
  output logic        bad2_o,
  output logic        evt_flag_o,
  output logic        rst_req_o
);

  logic armed_q, armed_d;
  logic bad1_q, bad2_q, evt_q, req_q;
  logic arm_ok, kick_ok, bad1_now, bad2_now;

  always_comb begin
    arm_ok   = (wdata_i[15:8] == KEY_ARM);
    kick_ok  = (wdata_i[7:0] == KEY_KICK);
    svc_o    = en_i && clr_wr_i && armed_q && kick_ok && win_open_i;
    bad1_now = en_i && pre_wr_i && !arm_ok;
    bad2_now = en_i && clr_wr_i && !svc_o;
    evt_o    = bad1_now || bad2_now || expire_i;

    armed_d = armed_q;
    if (!en_i)         armed_d = 1'b0;
    else if (pre_wr_i) armed_d = arm_ok;
    else if (clr_wr_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
      evt_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      bad1_q  <= bad1_q | bad1_now;
      bad2_q  <= bad2_q | bad2_now;
      evt_q   <= evt_q | evt_o;
      req_q   <= evt_o;
    end
  end

  assign bad1_o     = bad1_q;
  assign bad2_o     = bad2_q;
  assign evt_flag_o = evt_q;
  assign rst_req_o  = req_q;

  AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> evt_q); // R10
  AST_REQ_WITH_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> evt_q); // R9
  AST_BAD_MEANS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad1_q || bad2_q) |-> evt_q); // R7
  AST_DISARMED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed_q); // R13

endmodule

// File: rtl/keyed_deadman.sv
module keyed_deadman
  import kd_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PER_RST = 1000,
  parameter int unsigned WIN_RST = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              rst_req_o
);

  wr_strobe_t       strb;
  wr_kind_e         kind;
  logic [3:0]       rsel;
  logic             en, blk, cause;
  logic [CNT_W-1:0] per, win, count;
  logic             win_open, expire, svc, evt;
  logic             bad1, bad2, evt_flag;

  kd_bus_decode u_dec (
    .wr_en_i (bus_we_i),
    .addr_i  (bus_addr_i),
    .blk_i   (blk),
    .strb_o  (strb),
    .kind_o  (kind),
    .rsel_o  (rsel)
  );

  kd_cfg_regs #(
    .CNT_W   (CNT_W),
    .PER_RST (PER_RST),
    .WIN_RST (WIN_RST)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_i  (strb),
    .kind_i  (kind),
    .wdata_i (bus_wdata_i),
    .evt_i   (evt),
    .en_o    (en),
    .blk_o   (blk),
    .per_o   (per),
    .win_o   (win),
    .cause_o (cause)
  );

  kd_count_window #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .per_i      (per),
    .win_i      (win),
    .svc_i      (svc),
    .count_o    (count),
    .win_open_o (win_open),
    .expire_o   (expire)
  );

  kd_key_guard u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .pre_wr_i   (strb.pre),
    .clr_wr_i   (strb.clr),
    .wdata_i    (bus_wdata_i[15:0]),
    .win_open_i (win_open),
    .expire_i   (expire),
    .svc_o      (svc),
    .evt_o      (evt),
    .bad1_o     (bad1),
    .bad2_o     (bad2),
    .evt_flag_o (evt_flag),
    .rst_req_o  (rst_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (!blk) begin
      case (rsel)
        SEL_CTRL: bus_rdata_o[EN_BIT] = en;
        SEL_STAT: begin
          bus_rdata_o[ST_WIN]  = win_open;
          bus_rdata_o[ST_EVT]  = evt_flag;
          bus_rdata_o[ST_BAD2] = bad2;
          bus_rdata_o[ST_BAD1] = bad1;
        end
        SEL_CNT:   bus_rdata_o = BUS_W'(count);
        SEL_PER:   bus_rdata_o = BUS_W'(per);
        SEL_WIN:   bus_rdata_o = BUS_W'(win);
        SEL_CAUSE: bus_rdata_o[CAUSE_BIT] = cause;
        default:   ;
      endcase
    end
  end

endmodule

// File: tb/tb_keyed_deadman.sv
`timescale 1ns/100ps
module tb_keyed_deadman;

  localparam int CW = 8;
  localparam int PR = 12;
  localparam int WR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rreq;
  int          n_run = 0;
  int          n_fail = 0;

  keyed_deadman #(.CNT_W(CW), .PER_RST(PR), .WIN_RST(WR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rst_req_o(rreq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; we = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run hung (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int st, cexp, guard;
    bit ok, wbit;

    // R1 reset values
    do_reset;
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h30, v); check("R1 status", v, 0);
    rd(8'h40, v); check("R1 count", v, 0);
    rd(8'h60, v); check("R1 limit", v, PR);
    rd(8'h70, v); check("R1 window", v, WR);
    rd(8'h80, v); check("R1 cause", v, 0);
    check("R1 rst_req", rreq, 0);

    // R2 write forms and alignment
    wr(8'h08, 32'h8000); rd(8'h00, v); check("R2 set form", v, 32'h8000);
    wr(8'h0C, 32'h0);    rd(8'h00, v); check("R2 no-effect form", v, 32'h8000);
    wr(8'h01, 32'h0);    rd(8'h00, v); check("R2 unaligned", v, 32'h8000);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 ctrl mask", v, 32'h8000);
    wr(8'h04, 32'h8000); tick(1); rd(8'h00, v); check("R2 clear form", v, 0);

    // R3 counting and idle
    do_reset;
    wr(8'h00, 32'h8000); tick(5);
    rd(8'h40, v); check("R3 count after 5", v, 5);
    wr(8'h04, 32'h8000); tick(1);
    rd(8'h40, v); check("R3 held at zero", v, 0);

    // R4 limit lock
    do_reset;
    wr(8'h00, 32'h8000);
    wr(8'h60, 32'd3); rd(8'h60, v); check("R4 limit locked", v, PR);
    wr(8'h70, 32'd1); rd(8'h70, v); check("R4 window locked", v, WR);
    wr(8'h04, 32'h8000); tick(1);
    wr(8'h60, 32'd3); rd(8'h60, v); check("R4 limit written", v, 3);

    // R9 expiry with limit 6
    do_reset;
    wr(8'h60, 32'd6); wr(8'h70, 32'd2); wr(8'h00, 32'h8000);
    for (int n = 0; n < 10; n++) begin
      rd(8'h40, v);
      check($sformatf("R9 count n=%0d", n), v, (n < 6) ? n : 6);
      check($sformatf("R9 pulse n=%0d", n), rreq, (n == 6) ? 1 : 0);
      tick(1);
    end
    rd(8'h30, v); check("R9 status", v, 32'h20);
    rd(8'h80, v); check("R11 cause on expiry", v, 32'h20);

    // R7 bad first key, R10 sticky, R11 clear
    do_reset;
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4100); check("R7 pulse", rreq, 1);
    rd(8'h30, v); check("R7 status", v, 32'hA0);
    wr(8'h30, 32'h0); wr(8'h34, 32'hFF);
    rd(8'h30, v); check("R10 sticky status", v, 32'hA0);
    rd(8'h80, v); check("R11 cause set", v, 32'h20);
    wr(8'h84, 32'h20); rd(8'h80, v); check("R11 cause cleared", v, 0);

    // R8 unarmed and wrong value
    do_reset;
    wr(8'h60, 32'd4); wr(8'h70, 32'd4); wr(8'h00, 32'h8000);
    wr(8'h20, 32'h08); check("R8 unarmed pulse", rreq, 1);
    rd(8'h30, v); check("R8 unarmed status", v & 32'hE0, 32'h60);
    do_reset;
    wr(8'h60, 32'd4); wr(8'h70, 32'd4); wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4000); wr(8'h20, 32'h09); check("R8 wrong value pulse", rreq, 1);
    rd(8'h30, v); check("R8 wrong value status", v & 32'hE0, 32'h60);

    // R12 blackout
    do_reset;
    wr(8'h00, 32'h8000); wr(8'h04, 32'h8000);
    rd(8'h60, v); check("R12 read zero", v, 0);
    wr(8'h60, 32'd5); rd(8'h60, v); check("R12 write ignored", v, PR);
    wr(8'h60, 32'd5); rd(8'h60, v); check("R12 write after", v, 5);

    // R13 keys while disabled / through alias forms
    do_reset;
    wr(8'h60, 32'd4); wr(8'h70, 32'd4);
    wr(8'h10, 32'h4100); rd(8'h30, v); check("R13 off no fault", v, 0);
    check("R13 off no pulse", rreq, 0);
    wr(8'h10, 32'h4000); wr(8'h00, 32'h8000);
    wr(8'h20, 32'h08); rd(8'h30, v); check("R13 off did not arm", v & 32'hE0, 32'h60);
    do_reset;
    wr(8'h60, 32'd4); wr(8'h70, 32'd4); wr(8'h00, 32'h8000);
    wr(8'h18, 32'h4100); rd(8'h30, v); check("R13 alias no fault", v & 32'hE0, 0);
    wr(8'h18, 32'h4000);
    wr(8'h20, 32'h08); rd(8'h30, v); check("R13 alias did not arm", v & 32'hE0, 32'h60);

    // R5 R6 R8 sweep over limit, window and service point
    for (int p = 3; p <= 7; p++) begin
      for (int w = 0; w <= p; w++) begin
        for (int t = 1; t <= p; t++) begin
          st = (w >= p) ? 0 : p - w;
          ok = (t >= st) && (t < p);
          cexp = ok ? 0 : ((t + 1 < p) ? t + 1 : p);
          wbit = (cexp >= st) && (cexp < p);
          do_reset;
          wr(8'h60, p); wr(8'h70, w); wr(8'h00, 32'h8000);
          guard = 0;
          rd(8'h40, v);
          while (v != t - 1 && guard < 40) begin
            tick(1); rd(8'h40, v); guard++;
          end
          wr(8'h10, 32'h4000);
          wr(8'h20, 32'h08);
          check($sformatf("R6/R8 pulse p=%0d w=%0d t=%0d", p, w, t), rreq, ok ? 0 : 1);
          rd(8'h40, v);
          check($sformatf("R6 count p=%0d w=%0d t=%0d", p, w, t), v, cexp);
          rd(8'h30, v);
          check($sformatf("R5 status p=%0d w=%0d t=%0d", p, w, t), v,
                (wbit ? 32'h1 : 32'h0) | (ok ? 32'h0 : 32'h60));
          rd(8'h80, v);
          check($sformatf("R11 cause p=%0d w=%0d t=%0d", p, w, t), v, ok ? 0 : 32'h20);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule